// File: doc/BRIEF.md
# Conditional Relative Jump Unit

This block owns the program counter of a small 16-bit processor and resolves the processor's relative jumps. Each cycle it looks at the current instruction word and at four status flags: negative, zero, carry and overflow. If the instruction is a jump, it picks one of eight conditions and works out the address of the next instruction. A taken jump lands at the sequential address plus a signed displacement counted in words. An untaken jump, or any other instruction, steps past one 16-bit word.

The block never writes a flag. The next address appears combinationally, along with a taken strobe and a jump-recognised strobe. The stored counter loads that address only on cycles where the surrounding pipeline asserts the step input. A synchronous reset loads a parameterised start address.

Top module: `jump_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` becomes `RESET_PC` on that edge. The default value of `RESET_PC` is 16'h4400.
- R2: `is_jump` is 1 exactly when `insn[15:13]` equals 3'b001. `taken` is never 1 while `is_jump` is 0.
- R3: For a jump, the condition field `insn[12:10]` selects when `taken` is 1:
  - 0: when Z is clear.
  - 1: when Z is set.
  - 2: when C is clear.
  - 3: when C is set.
  - 4: when N is set.
  - 5: when N equals V.
  - 6: when N differs from V.
  - 7: always.
- R4: When `taken` is 1, `pc_next` equals `pc_q + 2 + 2*sext(insn[9:0])`, computed modulo 2^16.
- R5: When `taken` is 0, `pc_next` equals `pc_q + 2`. This holds whatever the instruction is.
- R6: At a rising edge with `step` = 1, `pc_q` loads `pc_next`. With `step` = 0, `pc_q` holds its value.
- R7: Bit 0 of both `pc_q` and `pc_next` is always 0.
- R8: The offset extremes are handled correctly. Offset 10'h1FF displaces the target by +1022 bytes, and offset 10'h200 displaces it by -1024 bytes, both relative to `pc_q + 2`.
- R9: Word 16'h2FE4 is a carry-set jump with offset -28 words. With C = 1 it targets `pc_q + 2 - 56`. With C = 0 it targets `pc_q + 2`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance the stored counter this cycle |
| insn | input | 16 | Current instruction word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| pc_q | output | 16 | Address of the current instruction |
| pc_next | output | 16 | Address of the following instruction |
| taken | output | 1 | Jump condition met |
| is_jump | output | 1 | Instruction is a jump |

## Verification
Two functions can fall in the same cycle: resolving the condition, and committing the counter. A taken jump can arrive with `step` high, and the register must capture the branch target. The same jump can also arrive with `step` low, and the register must hold.

Random stimulus covers both cases. It toggles `step` independently of random jump and non-jump words and random flags. After each edge, a bench model of the counter is compared against `pc_q`. The comparison tells a register that follows its own input apart from one that ignores the decision.

// File: rtl/jump_unit.sv
module jump_unit #(
  parameter int W = 16,
  parameter logic [15:0] RESET_PC = 16'h4400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [15:0]  insn,
  input  logic         flag_n,
  input  logic         flag_z,
  input  logic         flag_c,
  input  logic         flag_v,
  output logic [15:0]  pc_q,
  output logic [15:0]  pc_next,
  output logic         taken,
  output logic         is_jump
);
  localparam int OFF_W = 10;
  localparam int EXT_W = W - OFF_W - 1;

  logic [2:0]   cond;
  logic         hit;
  logic [W-1:0] disp, seq_pc;

  assign is_jump = (insn[15:13] == 3'b001);
  assign cond    = insn[12:10];
  assign disp    = {{EXT_W{insn[OFF_W-1]}}, insn[OFF_W-1:0], 1'b0};
  assign seq_pc  = pc_q + W'(2);

  always_comb begin
    unique case (cond)
      3'd0: hit = !flag_z;
      3'd1: hit = flag_z;
      3'd2: hit = !flag_c;
      3'd3: hit = flag_c;
      3'd4: hit = flag_n;
      3'd5: hit = (flag_n == flag_v);
      3'd6: hit = (flag_n != flag_v);
      default: hit = 1'b1;
    endcase
  end

  assign taken   = is_jump && hit;
  assign pc_next = taken ? (seq_pc + disp) : seq_pc;

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= {RESET_PC[W-1:1], 1'b0};
    else if (step) pc_q <= pc_next;
  end
endmodule

// File: rtl/jump_unit_chk.sv
module jump_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        step,
  input logic [15:0] insn,
  input logic        flag_c,
  input logic [15:0] pc_q,
  input logic [15:0] pc_next,
  input logic        taken,
  input logic        is_jump
);
  p_taken_needs_jump_r2: assert property (@(posedge clk) disable iff (rst)
    taken |-> is_jump);
  p_always_cond_r3: assert property (@(posedge clk) disable iff (rst)
    (is_jump && insn[12:10] == 3'd7) |-> taken);
  p_carry_set_r3: assert property (@(posedge clk) disable iff (rst)
    (is_jump && insn[12:10] == 3'd3) |-> (taken == flag_c));
  p_sequential_r5: assert property (@(posedge clk) disable iff (rst)
    !taken |-> (pc_next == pc_q + 16'd2));
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    step |=> (pc_q == $past(pc_next)));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pc_q));
  p_even_r7: assert property (@(posedge clk) disable iff (rst)
    (pc_q[0] == 1'b0) && (pc_next[0] == 1'b0));
endmodule

bind jump_unit jump_unit_chk u_chk (
  .clk(clk), .rst(rst), .step(step), .insn(insn), .flag_c(flag_c),
  .pc_q(pc_q), .pc_next(pc_next), .taken(taken), .is_jump(is_jump)
);

// File: tb/jump_unit_bench.sv
module jump_unit_bench;
  logic clk = 1'b0, rst = 1'b1, step = 1'b0;
  logic [15:0] insn = 16'h0000;
  logic fn = 0, fz = 0, fc = 0, fv = 0;
  logic [15:0] pc_q, pc_next;
  logic taken, is_jump;
  int total = 0, bad = 0;
  logic [15:0] pc_m;

  always #2.5 clk = ~clk;

  jump_unit u_jump_unit (
    .clk(clk), .rst(rst), .step(step), .insn(insn),
    .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
    .pc_q(pc_q), .pc_next(pc_next), .taken(taken), .is_jump(is_jump)
  );

  function automatic logic m_take(input logic [15:0] i, input logic n, z, c, v);
    if (i[15:13] != 3'b001) return 1'b0;
    case (i[12:10])
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !c;
      3'd3: return c;
      3'd4: return n;
      3'd5: return n == v;
      3'd6: return n != v;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] m_next(input logic [15:0] pc, input logic [15:0] i,
                                         input logic t);
    logic [15:0] d;
    d = {{5{i[9]}}, i[9:0], 1'b0};
    return t ? pc + 16'd2 + d : pc + 16'd2;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] i, input logic [3:0] f, input logic s,
                       input string req);
    logic t;
    logic [15:0] e;
    @(negedge clk);
    insn = i; {fn, fz, fc, fv} = f; step = s;
    #1;
    t = m_take(i, f[3], f[2], f[1], f[0]);
    e = m_next(pc_m, i, t);
    chk({req, " is_jump R2"}, {15'd0, is_jump}, {15'd0, i[15:13] == 3'b001});
    chk({req, " taken R3"}, {15'd0, taken}, {15'd0, t});
    chk({req, " pc_next R4/R5"}, pc_next, e);
    chk({req, " even R7"}, {15'd0, pc_next[0]}, 16'd0);
    @(posedge clk); #1;
    if (s) pc_m = e;
    chk({req, " commit R6"}, pc_q, pc_m);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    repeat (2) @(posedge clk);
    #1;
    chk("reset R1", pc_q, 16'h4400);
    @(negedge clk); rst = 1'b0;
    pc_m = 16'h4400;

    apply(16'h2FE4, 4'b0010, 1'b1, "R9 carry set");
    chk("R9 target", pc_m, 16'h4400 + 16'd2 - 16'd56);
    apply(16'h2FE4, 4'b0000, 1'b1, "R9 carry clear");
    apply(16'h3DFF, 4'b0000, 1'b1, "R8 max fwd");
    apply(16'h3E00, 4'b0000, 1'b1, "R8 max back");
    apply(16'h3C05, 4'b0000, 1'b0, "R6 hold on taken");
    apply(16'h4504, 4'b1111, 1'b1, "R5 non-jump");
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++)
        apply({3'b001, c[2:0], 10'h003}, f[3:0], 1'b1, "R3 table");

    for (int k = 0; k < 400; k++) begin
      logic [15:0] r;
      r = 16'($urandom);
      if ($urandom % 2) r[15:13] = 3'b001;
      apply(r, 4'($urandom), 1'($urandom), "random R4");
    end

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("re-reset R1", pc_q, 16'h4400);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule